// File: doc/BRIEF.md
# Interrupt Status, Mask and DMA-Interrupt Register Unit

This block collects interrupt requests for a processor and holds the DMA interrupt control word that feeds one of them. It has three memory-mapped registers: a pending-interrupt status register, a mask register, and a DMA interrupt control register. A simple register bus reaches all three. The bus has a 32-bit byte address, four byte-lane enables and separate read and write strobes. Read data is combinational and is valid in the same cycle as the read strobe. Writes take effect at the next rising clock edge.

Peripheral sources raise pending bits with one-cycle pulses. DMA channels report completion with one-cycle pulses, and each pulse is latched into a per-channel flag when that channel is enabled. When the DMA interrupt condition becomes true, one pending bit of the status register (the DMA source bit, bit 3) is set. A sent bit in the DMA control word stops that pending bit from being raised again while the condition stays true. The processor request output is the OR over all status bits that are also set in the mask.

Software acknowledges a pending bit by writing zero to it. Software clears a DMA flag by writing one to it. The two registers therefore follow opposite conventions.

Top module: `intc_dma_regs`

## Requirements
- R1: Before decoding, the address is ANDed with 0x1FFFFFFF. Addresses that differ only in bits 31..29 (for example 0x1F801070, 0x9F801070 and 0xBF801070) reach the same register. Address bits 1..0 are ignored, and byte lanes are chosen by the enables.
- R2: The status register sits at word 0x1F801070, the mask at 0x1F801074 and the DMA control word at 0x1F8010F4. A read of one of these returns its contents, with status and mask zero-extended from NUM_SRC bits. A read of any other address returns 0.
- R3: A status write ANDs each enabled byte lane into the current contents. A 0 acknowledges a bit and a 1 leaves it unchanged. Lanes whose enable is low are left untouched.
- R4: A mask write replaces the enabled byte lanes. If the new mask overlaps a pending bit, cpu_irq is high in the cycle after the write edge.
- R5: A source pulse on src_pulse[i] sets status bit i. A pulse and an acknowledge of the same bit in the same cycle leave the bit set.
- R6: A DMA control write loads only the bits in 0x00FF803F from the written value: bits 5..0, the force bit 15, the channel enables 22..16 and the global enable 23. Lanes whose enable is low keep their old bits. Bits 14..6 read as 0, and bit 31 cannot be written.
- R7: In the DMA control word, writing 1 to flag bit 24+n clears it and writing 0 keeps it.
- R8: A pulse on dma_done[n] sets flag bit 24+n only while enable bit 16+n is set. If the pulse coincides with a clear, the pulse wins.
- R9: The DMA condition is (bit 23 AND any flag in 30..24) OR bit 15. When the condition turns from false to true, status bit 3 is set once. While the condition stays true, status bit 3 is not raised again, even after it has been acknowledged.
- R10: Bit 31 (sent) always equals the DMA condition of the stored word. When the condition becomes false, bit 31 clears, and a later condition raises status bit 3 again.
- R11: cpu_irq is high exactly when the status register ANDed with the mask is nonzero.
- R12: After reset the status register, the mask register and the DMA control word all read 0, and cpu_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when bus_rd is low |
| src_pulse | input | NUM_SRC | Per-source interrupt pulses |
| dma_done | input | NUM_DMA | Per-channel DMA-complete pulses |
| cpu_irq | output | 1 | Processor interrupt request |

## Verification
The acknowledge property assumes that no source pulse arrives in the cycle of a full-word status write. It also ignores the DMA bit, because a DMA raise may land in the same edge as the write. The mask property assumes that all four lanes are enabled. The property linking status bit 3 to the sent bit assumes that no source pulse arrives on bit 3, so that the only way to set that bit is a DMA raise. The directed stimulus applies source pulses and full-lane writes in separate cycles, except in the single case that tests a pulse and an acknowledge together. It never pulses source bit 3, so every rise of that bit comes from the DMA path.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam logic [31:0] SEG_MASK        = 32'h1FFF_FFFF;
   localparam logic [31:0] DMA_DIRECT_MASK = 32'h00FF_803F;
   localparam int          FORCE_BIT       = 15;
   localparam int          EN_LSB          = 16;
   localparam int          GLOBAL_BIT      = 23;
   localparam int          FLAG_LSB        = 24;
   localparam int          MAX_DMA         = 7;
   localparam int          SENT_BIT        = 31;

   typedef enum logic [1:0] {SEL_NONE, SEL_STAT, SEL_MASK, SEL_DMA} reg_sel_e;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
      return m;
   endfunction
endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
   import intc_pkg::*;
#(
   parameter logic [31:0] STAT_ADDR = 32'h1F80_1070,
   parameter logic [31:0] MASK_ADDR = 32'h1F80_1074,
   parameter logic [31:0] DMA_ADDR  = 32'h1F80_10F4
) (
   input  logic [31:0] addr,
   output reg_sel_e    sel
);
   localparam logic [31:0] WORD_MASK = 32'hFFFF_FFFC;
   localparam logic [31:0] STAT_W    = STAT_ADDR & WORD_MASK;
   localparam logic [31:0] MASK_W    = MASK_ADDR & WORD_MASK;
   localparam logic [31:0] DMA_W     = DMA_ADDR & WORD_MASK;

   logic [31:0] word;
   assign word = addr & SEG_MASK & WORD_MASK;

   always_comb begin
      if (word == STAT_W)      sel = SEL_STAT;
      else if (word == MASK_W) sel = SEL_MASK;
      else if (word == DMA_W)  sel = SEL_DMA;
      else                     sel = SEL_NONE;
   end
endmodule

// File: rtl/intc_status.sv
module intc_status #(
   parameter int NUM_SRC     = 11,
   parameter int DMA_SRC_BIT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_stat,
   input  logic               wr_mask,
   input  logic [NUM_SRC-1:0] wdata,
   input  logic [NUM_SRC-1:0] lanes,
   input  logic [NUM_SRC-1:0] src_pulse,
   input  logic               dma_raise,
   output logic [NUM_SRC-1:0] stat_q,
   output logic [NUM_SRC-1:0] mask_q
);
   logic [NUM_SRC-1:0] keep, set_vec, stat_d, mask_d;

   always_comb begin
      keep             = wdata | ~lanes;
      set_vec          = src_pulse;
      set_vec[DMA_SRC_BIT] = src_pulse[DMA_SRC_BIT] | dma_raise;
      stat_d           = (wr_stat ? (stat_q & keep) : stat_q) | set_vec;
      mask_d           = wr_mask ? ((mask_q & ~lanes) | (wdata & lanes)) : mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= stat_d;
         mask_q <= mask_d;
      end
   end
endmodule

// File: rtl/intc_dma_ctrl.sv
module intc_dma_ctrl
   import intc_pkg::*;
#(
   parameter int NUM_DMA = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [31:0]        wdata,
   input  logic [31:0]        lanes,
   input  logic [NUM_DMA-1:0] dma_done,
   output logic [31:0]        icr_q,
   output logic               raise
);
   if (NUM_DMA < 1 || NUM_DMA > MAX_DMA) begin : g_bad_dma
      $error("intc_dma_ctrl: NUM_DMA must be 1..7");
   end

   logic [31:0]        direct_q, direct_d, wr_merge, wr_on;
   logic [MAX_DMA-1:0] flags_q, flags_d, set_v, clr_v;
   logic               sent_q, cond_d;

   for (genvar n = 0; n < MAX_DMA; n++) begin : g_chan
      if (n < NUM_DMA) begin : g_live
         assign set_v[n] = dma_done[n] & direct_q[EN_LSB+n];
      end else begin : g_dead
         assign set_v[n] = 1'b0;
      end
   end

   always_comb begin
      wr_on    = wdata & lanes;
      wr_merge = wr_on | (direct_q & ~lanes);
      direct_d = wr ? (wr_merge & DMA_DIRECT_MASK) : direct_q;
      clr_v    = wr ? wr_on[FLAG_LSB +: MAX_DMA] : '0;
      flags_d  = (flags_q & ~clr_v) | set_v;
      cond_d   = (direct_d[GLOBAL_BIT] & (|flags_d)) | direct_d[FORCE_BIT];
      raise    = cond_d & ~sent_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         direct_q <= '0;
         flags_q  <= '0;
         sent_q   <= 1'b0;
      end else begin
         direct_q <= direct_d;
         flags_q  <= flags_d;
         sent_q   <= cond_d;
      end
   end

   assign icr_q = {sent_q, flags_q, direct_q[23:0]};
endmodule

// File: rtl/intc_dma_regs.sv
module intc_dma_regs
   import intc_pkg::*;
#(
   parameter int          NUM_SRC     = 11,
   parameter int          NUM_DMA     = 7,
   parameter int          DMA_SRC_BIT = 3,
   parameter logic [31:0] STAT_ADDR   = 32'h1F80_1070,
   parameter logic [31:0] MASK_ADDR   = 32'h1F80_1074,
   parameter logic [31:0] DMA_ADDR    = 32'h1F80_10F4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [31:0]        bus_addr,
   input  logic [3:0]         bus_be,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_pulse,
   input  logic [NUM_DMA-1:0] dma_done,
   output logic               cpu_irq
);
   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_src
      $error("intc_dma_regs: NUM_SRC must be 1..32");
   end
   if (DMA_SRC_BIT >= NUM_SRC) begin : g_bad_bit
      $error("intc_dma_regs: DMA_SRC_BIT must lie inside NUM_SRC");
   end

   reg_sel_e           sel;
   logic [31:0]        lanes, icr_q;
   logic [NUM_SRC-1:0] stat_q, mask_q;
   logic               dma_raise;
   logic [31:0]        stat_ext, mask_ext;

   intc_addr_dec #(.STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR), .DMA_ADDR(DMA_ADDR))
      u_dec (.addr(bus_addr), .sel(sel));

   assign lanes = lane_mask(bus_be);

   intc_dma_ctrl #(.NUM_DMA(NUM_DMA)) u_dma (
      .clk(clk), .rst_n(rst_n),
      .wr(bus_wr && sel == SEL_DMA),
      .wdata(bus_wdata), .lanes(lanes),
      .dma_done(dma_done), .icr_q(icr_q), .raise(dma_raise));

   intc_status #(.NUM_SRC(NUM_SRC), .DMA_SRC_BIT(DMA_SRC_BIT)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .wr_stat(bus_wr && sel == SEL_STAT),
      .wr_mask(bus_wr && sel == SEL_MASK),
      .wdata(bus_wdata[NUM_SRC-1:0]), .lanes(lanes[NUM_SRC-1:0]),
      .src_pulse(src_pulse), .dma_raise(dma_raise),
      .stat_q(stat_q), .mask_q(mask_q));

   always_comb begin
      stat_ext = '0;
      mask_ext = '0;
      stat_ext[NUM_SRC-1:0] = stat_q;
      mask_ext[NUM_SRC-1:0] = mask_q;
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (sel)
            SEL_STAT: bus_rdata = stat_ext;
            SEL_MASK: bus_rdata = mask_ext;
            SEL_DMA:  bus_rdata = icr_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign cpu_irq = |(stat_q & mask_q);
endmodule

// File: rtl/intc_dma_regs_chk.sv
module intc_dma_regs_chk #(
   parameter int          NUM_SRC     = 11,
   parameter int          NUM_DMA     = 7,
   parameter int          DMA_SRC_BIT = 3,
   parameter logic [31:0] STAT_ADDR   = 32'h1F80_1070,
   parameter logic [31:0] MASK_ADDR   = 32'h1F80_1074
) (
   input logic               clk,
   input logic               rst_n,
   input logic [31:0]        bus_addr,
   input logic [3:0]         bus_be,
   input logic               bus_wr,
   input logic [31:0]        bus_wdata,
   input logic [NUM_SRC-1:0] src_pulse,
   input logic [NUM_DMA-1:0] dma_done,
   input logic [NUM_SRC-1:0] stat_q,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [31:0]        icr_q
);
   localparam logic [31:0] WM = 32'h1FFF_FFFC;
   localparam logic [NUM_SRC-1:0] NOT_DMA = ~(NUM_SRC'(1) << DMA_SRC_BIT);

   logic stat_full_wr, mask_full_wr;
   assign stat_full_wr = bus_wr && bus_be == 4'hF && (bus_addr & WM) == (STAT_ADDR & WM);
   assign mask_full_wr = bus_wr && bus_be == 4'hF && (bus_addr & WM) == (MASK_ADDR & WM);

   // R3: zeros written to the status register acknowledge those bits
   assert_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_full_wr && src_pulse == '0 |=>
      ((stat_q & ~$past(bus_wdata[NUM_SRC-1:0]) & NOT_DMA) == '0));

   // R4: a full-lane mask write replaces the mask
   assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mask_full_wr |=> mask_q == $past(bus_wdata[NUM_SRC-1:0]));

   // R8: an enabled completion pulse always leaves its flag set
   for (genvar n = 0; n < NUM_DMA; n++) begin : g_flag
      assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
         dma_done[n] && icr_q[16+n] |=> icr_q[24+n]);
   end

   // R9: a DMA-driven rise of the status bit comes with a rise of the sent bit
   assert_raise_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[DMA_SRC_BIT]) && !$past(src_pulse[DMA_SRC_BIT]) |-> $rose(icr_q[31]));

   // R10: the sent bit tracks the condition of the stored word
   assert_sent_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
      icr_q[31] == ((icr_q[23] && (|icr_q[30:24])) || icr_q[15]));
endmodule

bind intc_dma_regs intc_dma_regs_chk #(
   .NUM_SRC(NUM_SRC), .NUM_DMA(NUM_DMA), .DMA_SRC_BIT(DMA_SRC_BIT),
   .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
   .bus_wr(bus_wr), .bus_wdata(bus_wdata), .src_pulse(src_pulse),
   .dma_done(dma_done), .stat_q(stat_q), .mask_q(mask_q), .icr_q(icr_q)
);

// File: tb/tb_intc_dma_regs.sv
module tb_intc_dma_regs;
   localparam int NUM_SRC = 11;
   localparam int NUM_DMA = 7;
   localparam logic [31:0] A_STAT = 32'h1F80_1070;
   localparam logic [31:0] A_MASK = 32'h1F80_1074;
   localparam logic [31:0] A_DMA  = 32'h1F80_10F4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [31:0]        bus_addr = '0;
   logic [3:0]         bus_be = '0;
   logic               bus_wr = 1'b0;
   logic               bus_rd = 1'b0;
   logic [31:0]        bus_wdata = '0;
   logic [31:0]        bus_rdata;
   logic [NUM_SRC-1:0] src_pulse = '0;
   logic [NUM_DMA-1:0] dma_done = '0;
   logic               cpu_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   intc_dma_regs #(.NUM_SRC(NUM_SRC), .NUM_DMA(NUM_DMA)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .src_pulse(src_pulse), .dma_done(dma_done),
      .cpu_irq(cpu_irq));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d,
                     input logic [3:0] be = 4'hF, input logic [NUM_SRC-1:0] p = '0);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1; src_pulse = p;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0; src_pulse = '0;
   endtask

   task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 chk(tag, bus_rdata, exp);
      bus_rd = 1'b0;
   endtask

   task automatic pulse_src(input logic [NUM_SRC-1:0] p);
      @(negedge clk); src_pulse = p;
      @(negedge clk); src_pulse = '0;
   endtask

   task automatic pulse_dma(input logic [NUM_DMA-1:0] p);
      @(negedge clk); dma_done = p;
      @(negedge clk); dma_done = '0;
   endtask

   task automatic irq_chk(input string tag, input logic exp);
      @(negedge clk);
      #1 chk(tag, {31'd0, cpu_irq}, {31'd0, exp});
   endtask

   task automatic t_reset;
      rd_chk("R12 status after reset", A_STAT, 32'h0);
      rd_chk("R12 mask after reset", A_MASK, 32'h0);
      rd_chk("R12 dma word after reset", A_DMA, 32'h0);
      irq_chk("R12 irq after reset", 1'b0);
   endtask

   task automatic t_decode;
      wr(A_MASK, 32'hFFFF_FFFF);
      rd_chk("R2 mask zero-extended", A_MASK, 32'h0000_07FF);
      rd_chk("R1 mask via mirror 0x9F", 32'h9F80_1074, 32'h0000_07FF);
      rd_chk("R2 unmapped word reads zero", 32'h1F80_1078, 32'h0);
      wr(32'hBF80_1074, 32'h0);
      rd_chk("R1 write via mirror 0xBF", A_MASK, 32'h0);
   endtask

   task automatic t_pulse_ack;
      pulse_src(11'h021);
      rd_chk("R5 pulses set status", A_STAT, 32'h021);
      irq_chk("R11 masked pending gives no irq", 1'b0);
      wr(A_MASK, 32'h020);
      #1 chk("R4 irq right after overlapping mask write", {31'd0, cpu_irq}, 32'd1);
      wr(32'hBF80_1070, 32'hFFFF_FFDF);
      rd_chk("R3 zero acknowledges, ones keep", A_STAT, 32'h001);
      irq_chk("R11 irq drops after ack", 1'b0);
      pulse_src(11'h200);
      wr(A_STAT, 32'h0, 4'b0001);
      rd_chk("R3 disabled lane untouched", A_STAT, 32'h200);
      wr(A_STAT, 32'h0, 4'hF, 11'h004);
      rd_chk("R5 pulse beats same-cycle ack", A_STAT, 32'h004);
      wr(A_STAT, 32'h0);
      wr(A_MASK, 32'hFFFF_FFFF, 4'b0010);
      rd_chk("R4 mask lane replace", A_MASK, 32'h720);
      wr(A_MASK, 32'h0);
   endtask

   task automatic t_dma_write;
      wr(A_DMA, 32'h7F7F_7FC0);
      rd_chk("R6 only direct bits load", A_DMA, 32'h007F_0000);
      wr(A_DMA, 32'h0000_002A);
      rd_chk("R6 low field loads", A_DMA, 32'h0000_002A);
      wr(A_DMA, 32'hFFFF_FFFF, 4'b0100);
      rd_chk("R6 single lane write", A_DMA, 32'h00FF_002A);
      wr(A_DMA, 32'h0);
      rd_chk("R6 cleared", A_DMA, 32'h0);
   endtask

   task automatic t_dma_flags;
      wr(A_DMA, 32'h0003_0000);
      pulse_dma(7'b000_0101);
      rd_chk("R8 enabled channel flags, disabled ignored", A_DMA, 32'h0103_0000);
      rd_chk("R9 no raise without global enable", A_STAT, 32'h0);
      wr(A_DMA, 32'h0103_0000);
      rd_chk("R7 write one clears flag", A_DMA, 32'h0003_0000);
      pulse_dma(7'b000_0010);
      wr(A_DMA, 32'h0003_0000);
      rd_chk("R7 write zero keeps flag", A_DMA, 32'h0203_0000);
      wr(A_DMA, 32'h0203_0000);
      rd_chk("R7 second flag cleared", A_DMA, 32'h0003_0000);
   endtask

   task automatic t_dma_irq;
      wr(A_MASK, 32'h008);
      wr(A_DMA, 32'h0083_0000);
      rd_chk("R9 enabled but no flag: no sent", A_DMA, 32'h0083_0000);
      pulse_dma(7'b000_0001);
      rd_chk("R10 sent set with condition", A_DMA, 32'h8183_0000);
      rd_chk("R9 status bit 3 raised", A_STAT, 32'h008);
      irq_chk("R11 irq from dma source", 1'b1);
      wr(A_STAT, 32'hFFFF_FFF7);
      pulse_dma(7'b000_0010);
      rd_chk("R9 second flag while sent", A_DMA, 32'h8383_0000);
      rd_chk("R9 no second raise while sent", A_STAT, 32'h0);
      wr(A_DMA, 32'h0383_0000);
      rd_chk("R10 sent clears with condition", A_DMA, 32'h0083_0000);
      pulse_dma(7'b000_0001);
      rd_chk("R10 raise again after rearm", A_STAT, 32'h008);
      wr(A_STAT, 32'h0);
      wr(A_DMA, 32'h0100_0000);
      rd_chk("R10 all cleared", A_DMA, 32'h0);
      wr(A_DMA, 32'h0000_8000);
      rd_chk("R9 force bit sets sent", A_DMA, 32'h8000_8000);
      rd_chk("R9 force bit raises status", A_STAT, 32'h008);
      wr(A_STAT, 32'h0);
      rd_chk("R9 force held: no re-raise", A_STAT, 32'h0);
      wr(A_DMA, 32'h8000_0000);
      rd_chk("R6 bit 31 not writable", A_DMA, 32'h0);
      wr(A_MASK, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_decode();
      t_pulse_ack();
      t_dma_write();
      t_dma_flags();
      t_dma_irq();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule